// File: doc/BRIEF.md
# Sequential Bit Gather/Scatter Permuter with Stored Mask

This block applies one of four mask-driven bit permutations to an N-bit word over several clock steps. The number of steps is log2(N). Before data is processed, a mask is loaded through the same data input in a separate load operation. During the load, the block computes one routing-select word per step for two internal lanes. The "sheep" lane carries the bits at mask-one positions. The "goat" lane carries the bits at mask-zero positions. The stored selects are then reused by every later data operation until the next load completes.

A data operation works in one of two directions. It can pack the marked bits toward the low end: the unmarked bits go to the high end in reverse order, or they are cleared. It can also do the exact inverse: the low data bits are scattered into the marked positions, and the remaining bits fill the unmarked positions in reverse order, or are cleared. Each operation starts with a one-cycle start pulse. The ready output reports completion. A new start always abandons whatever is in flight.

Top module: `sag_seq_core`

## Requirements
- R1: After reset, ready_o is 1, dout_o is 0 and the stored mask is all zeros. Data operations issued before any load use this zero mask.
- R2: ready_o is 0 in the cycle after start_i is sampled. It returns to 1 exactly log2(N) cycles after the start edge (5 for N=32).
- R3: With op_load_i=1 at start, din_i becomes the new mask. The load takes the same log2(N) cycles as a data operation, and dout_o reads 0 once it completes.
- R4: With op_inv_i=0 and op_drop_i=0, the result is a pack. The mask-one bits of din_i appear in ascending order from bit 0 upward. The mask-zero bits appear from bit N-1 downward, with the lowest such bit at N-1.
- R5: With op_inv_i=0 and op_drop_i=1, the mask-one bits are packed as in R4 and all higher result bits are 0.
- R6: With op_inv_i=1 and op_drop_i=0, the result is a scatter and is the exact inverse of R4. The mask-one positions take din_i bits 0,1,2,... in ascending order. The mask-zero positions take din_i bits N-1, N-2, ... in ascending position order.
- R7: With op_inv_i=1 and op_drop_i=1, the mask-one positions are filled as in R6 and all mask-zero positions are 0.
- R8: Mode bits and din_i are sampled only on the start edge. Changing them while the operation runs does not alter its result.
- R9: A start issued while busy aborts the running operation. The result and the timing are those of the new operation alone.
- R10: A mask load that is aborted, including one aborted at its final step, leaves the previously stored mask in effect.
- R11: While ready_o is 1 and no start arrives, dout_o holds its value.
- R12: A loaded mask stays in effect across any number of data operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation; aborts one in progress |
| op_load_i | input | 1 | 1: din_i is a new mask |
| op_inv_i | input | 1 | 1: scatter direction (inverse), 0: pack direction |
| op_drop_i | input | 1 | 1: unmarked bits cleared, 0: unmarked bits kept reversed |
| din_i | input | N | Data word or mask word |
| ready_o | output | 1 | Last operation complete; dout_o valid |
| dout_o | output | N | Result |

## Verification
The assertions assume that start_i and the mode bits are known, non-X levels at every rising edge after reset. They also assume that a load request is never combined with a result expected from the same operation. The bench drives every input with defined values at falling edges only. It holds op_inv_i and op_drop_i at 0 whenever op_load_i starts a load. It randomises the inputs only after the start edge, so mid-operation changes stay within what R8 permits. The abort cases are placed deliberately: one start lands one cycle into an operation, and one lands exactly on the final load step.

// File: rtl/sag_pkg.sv
package sag_pkg;

  // Lane behaviour for the current operation
  typedef enum logic [1:0] {
    LM_LOAD   = 2'd0,  // compute per-step select words from a mask
    LM_PACK   = 2'd1,  // move marked bits toward bit 0
    LM_SPREAD = 2'd2   // inverse of pack: move low bits out to marked slots
  } lane_mode_e;

  typedef struct packed {
    logic load;
    logic inv;
    logic drop;
  } op_ctl_t;

  function automatic lane_mode_e pick_mode(op_ctl_t c);
    if (c.load)     return LM_LOAD;
    else if (c.inv) return LM_SPREAD;
    else            return LM_PACK;
  endfunction

endpackage

// File: rtl/sag_step_ctrl.sv
module sag_step_ctrl #(
  parameter int STEPS = 5,
  parameter int SW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [SW-1:0] step,
  output logic          last
);
  localparam logic [SW-1:0] LAST_IDX = SW'(STEPS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= '0;
    end else if (start) begin
      busy <= 1'b1;
      step <= '0;
    end else if (busy) begin
      if (step == LAST_IDX) busy <= 1'b0;
      else                  step <= step + 1'b1;
    end
  end

  assign last = busy && (step == LAST_IDX);

  // R2: a start always opens a fresh sequence at step 0
  a_r2_fresh_seq: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && step == '0));

  // R2: step index never runs past the final step
  a_r2_step_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (step <= LAST_IDX));

endmodule

// File: rtl/sag_lane.sv
module sag_lane
  import sag_pkg::*;
#(
  parameter int N  = 32,
  parameter int S  = 5,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  lane_mode_e    mode_in,
  input  logic [N-1:0]  seed_x,
  input  logic [N-1:0]  seed_k,
  input  logic          run,
  input  logic [SW-1:0] step,
  input  logic          last,
  output logic [N-1:0]  word
);
  localparam logic [SW-1:0] TOP_IDX = SW'(S - 1);

  lane_mode_e   mode_q;
  logic [N-1:0] x_q;
  logic [N-1:0] k_q;
  logic [N-1:0] sel_c [S];  // committed per-step selects
  logic [N-1:0] sel_p [S];  // selects being built by a load

  // prefix parity from bit 0 upward, log2(N) shift-xor levels
  function automatic logic [N-1:0] prefix_par(logic [N-1:0] v);
    for (int j = 0; j < S; j++) v = v ^ (v << (1 << j));
    return v;
  endfunction

  function automatic logic [N-1:0] pack_step(logic [N-1:0] x, logic [N-1:0] sel, int sh);
    logic [N-1:0] t;
    t = x & sel;
    return (x & ~t) | (t >> sh);
  endfunction

  function automatic logic [N-1:0] spread_step(logic [N-1:0] x, logic [N-1:0] sel, int sh);
    return (x & ~sel) | ((x << sh) & sel);
  endfunction

  logic [SW-1:0] rstep;
  logic [N-1:0]  par_w;
  logic [N-1:0]  mv_w;

  always_comb begin
    rstep = TOP_IDX - step;
    par_w = prefix_par(k_q);
    mv_w  = par_w & x_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= LM_PACK;
      x_q    <= '0;
      k_q    <= '0;
      for (int k = 0; k < S; k++) begin
        sel_c[k] <= '0;
        sel_p[k] <= '0;
      end
    end else if (start) begin
      mode_q <= mode_in;
      x_q    <= seed_x;
      k_q    <= seed_k;
    end else if (run) begin
      case (mode_q)
        LM_LOAD: begin
          x_q         <= pack_step(x_q, mv_w, 1 << step);
          k_q         <= k_q & ~par_w;
          sel_p[step] <= mv_w;
          if (last) begin
            for (int k = 0; k < S; k++)
              sel_c[k] <= (SW'(k) == step) ? mv_w : sel_p[k];
          end
        end
        LM_PACK:   x_q <= pack_step(x_q, sel_c[step], 1 << step);
        LM_SPREAD: x_q <= spread_step(x_q, sel_c[rstep], 1 << rstep);
        default:   x_q <= x_q;
      endcase
    end
  end

  assign word = x_q;

  // R4: loading and packing move bits without ever merging two of them
  a_r4_no_bit_merge: assert property (@(posedge clk) disable iff (rst)
    (run && !start && mode_q != LM_SPREAD) |=> ($countones(x_q) == $past($countones(x_q))));

endmodule

// File: rtl/sag_seq_core.sv
module sag_seq_core
  import sag_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         op_load_i,
  input  logic         op_inv_i,
  input  logic         op_drop_i,
  input  logic [N-1:0] din_i,
  output logic         ready_o,
  output logic [N-1:0] dout_o
);
  localparam int S     = $clog2(N);
  localparam int SW    = (S > 1) ? $clog2(S) : 1;
  localparam int LANES = 2;  // 0: marked bits, 1: unmarked bits

  function automatic logic [N-1:0] flip(logic [N-1:0] v);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = v[N-1-i];
    return r;
  endfunction

  // sequencing
  logic          busy_w;
  logic [SW-1:0] step_w;
  logic          last_w;

  sag_step_ctrl #(.STEPS(S), .SW(SW)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start_i),
    .busy  (busy_w),
    .step  (step_w),
    .last  (last_w)
  );

  // operation state captured on the start edge
  op_ctl_t      ctl_in;
  op_ctl_t      ctl_q;
  logic [N-1:0] mask_q;
  logic [N-1:0] mask_new_q;
  logic         mask_commit;

  assign ctl_in      = '{load: op_load_i, inv: op_inv_i, drop: op_drop_i};
  assign mask_commit = last_w && ctl_q.load && !start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= '0;
      mask_q     <= '0;
      mask_new_q <= '0;
    end else begin
      if (start_i) begin
        ctl_q      <= ctl_in;
        mask_new_q <= din_i;
      end
      if (mask_commit) mask_q <= mask_new_q;
    end
  end

  // lane seeds
  logic [N-1:0] seed_x [LANES];
  logic [N-1:0] seed_k [LANES];
  logic [N-1:0] word_w [LANES];
  lane_mode_e   mode_w;

  always_comb begin
    mode_w = pick_mode(ctl_in);
    seed_k[0] = '0;
    seed_k[1] = '0;
    case (mode_w)
      LM_LOAD: begin
        seed_x[0] = din_i;
        seed_k[0] = ~din_i << 1;
        seed_x[1] = ~din_i;
        seed_k[1] = din_i << 1;
      end
      LM_SPREAD: begin
        seed_x[0] = din_i;
        seed_x[1] = flip(din_i);
      end
      default: begin
        seed_x[0] = din_i & mask_q;
        seed_x[1] = din_i & ~mask_q;
      end
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sag_lane #(.N(N), .S(S), .SW(SW)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .start   (start_i),
      .mode_in (mode_w),
      .seed_x  (seed_x[g]),
      .seed_k  (seed_k[g]),
      .run     (busy_w),
      .step    (step_w),
      .last    (last_w),
      .word    (word_w[g])
    );
  end

  // result assembly
  always_comb begin
    if (ctl_q.load)
      dout_o = '0;
    else if (ctl_q.inv)
      dout_o = (word_w[0] & mask_q) | (ctl_q.drop ? '0 : (word_w[1] & ~mask_q));
    else
      dout_o = word_w[0] | (ctl_q.drop ? '0 : flip(word_w[1]));
  end

  assign ready_o = !busy_w;

  // cycles since the last start, for the latency check
  logic [SW:0] since_q;
  always_ff @(posedge clk) begin
    if (rst)          since_q <= '0;
    else if (start_i) since_q <= '0;
    else if (busy_w)  since_q <= since_q + 1'b1;
  end

  // R2: ready falls right after a start
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !ready_o);

  // R2: completion arrives exactly log2(N) cycles after the start edge
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> (since_q == (SW+1)'(S)));

  // R10: the stored mask changes only when a load finishes uninterrupted
  a_r10_mask_guard: assert property (@(posedge clk) disable iff (rst)
    !(last_w && ctl_q.load && !start_i) |=> $stable(mask_q));

  // R11: an idle result does not drift
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !start_i) |=> $stable(dout_o));

endmodule

// File: tb/tb_sag_seq_core.sv
module tb_sag_seq_core;
  localparam int N = 32;
  localparam int S = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         op_load_i = 1'b0;
  logic         op_inv_i = 1'b0;
  logic         op_drop_i = 1'b0;
  logic [N-1:0] din_i = '0;
  logic         ready_o;
  logic [N-1:0] dout_o;

  always #2 clk = ~clk;  // 4 ns period

  sag_seq_core #(.N(N)) dut (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .op_load_i (op_load_i),
    .op_inv_i  (op_inv_i),
    .op_drop_i (op_drop_i),
    .din_i     (din_i),
    .ready_o   (ready_o),
    .dout_o    (dout_o)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [N-1:0] cur_mask = '0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // walk the word bit by bit: marked bits fill upward, unmarked fill downward
  function automatic logic [N-1:0] model(bit inv, bit drop, logic [N-1:0] d, logic [N-1:0] m);
    logic [N-1:0] r = '0;
    int lo = 0;
    int hi = N - 1;
    for (int i = 0; i < N; i++) begin
      if (m[i]) begin
        if (inv) r[i] = d[lo];
        else     r[lo] = d[i];
        lo++;
      end
    end
    if (!drop) begin
      for (int i = 0; i < N; i++) begin
        if (!m[i]) begin
          if (inv) r[i] = d[hi];
          else     r[hi] = d[i];
          hi--;
        end
      end
    end
    return r;
  endfunction

  function automatic string tag_of(int md);
    case (md)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // md: bit1 = inv, bit0 = drop
  task automatic launch(bit ld, int md, logic [N-1:0] d);
    @(negedge clk);
    start_i   = 1'b1;
    op_load_i = ld;
    op_inv_i  = ld ? 1'b0 : md[1];
    op_drop_i = ld ? 1'b0 : md[0];
    din_i     = d;
    @(negedge clk);
    start_i   = 1'b0;
    // R8: scramble every sampled input while the operation runs
    din_i     = $urandom;
    op_load_i = 1'($urandom);
    op_inv_i  = 1'($urandom);
    op_drop_i = 1'($urandom);
  endtask

  task automatic await_done(string req);
    int cyc = 0;
    chk({req, " R2 ready low after start"}, 64'(ready_o), 64'd0);
    while (!ready_o && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk({req, " R2 latency"}, 64'(cyc), 64'(S));
  endtask

  task automatic data_op(int md, logic [N-1:0] d, string req);
    launch(1'b0, md, d);
    await_done(req);
    chk(req, 64'(dout_o), 64'(model(md[1], md[0], d, cur_mask)));
  endtask

  task automatic load_mask(logic [N-1:0] m);
    launch(1'b1, 0, m);
    await_done("R3");
    chk("R3 zero after load", 64'(dout_o), 64'd0);
    cur_mask = m;
  endtask

  initial begin
    logic [N-1:0] masks [8];
    logic [N-1:0] d, d2, held;
    void'($urandom(32'h5A61));
    masks[0] = '1;
    masks[1] = 32'h5555_5555;
    masks[2] = 32'h8000_0001;
    masks[3] = 32'h0000_FFFF;
    masks[4] = 32'hF0F0_0F0F;
    for (int i = 5; i < 8; i++) masks[i] = $urandom;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", 64'(ready_o), 64'd1);
    chk("R1 dout after reset", 64'(dout_o), 64'd0);

    // R1: zero mask in effect before any load
    for (int md = 0; md < 4; md++) data_op(md, $urandom, {"R1 ", tag_of(md)});

    // R11: idle output holds
    held = dout_o;
    repeat (3) @(negedge clk);
    chk("R11 hold", 64'(dout_o), 64'(held));

    // R12: each mask serves many operations
    for (int k = 0; k < 8; k++) begin
      load_mask(masks[k]);
      for (int md = 0; md < 4; md++)
        for (int r = 0; r < 3; r++)
          data_op(md, $urandom, {tag_of(md), " R8 R12"});
    end

    // R4/R6 corner data patterns on the current mask
    data_op(0, '1, "R4 all ones");
    data_op(2, 32'h0000_0001, "R6 single bit");

    // R9: abort a pack one cycle in with an extract on new data
    d  = $urandom;
    d2 = $urandom;
    launch(1'b0, 0, d);
    launch(1'b0, 1, d2);
    await_done("R9");
    chk("R9 aborted result", 64'(dout_o), 64'(model(1'b0, 1'b1, d2, cur_mask)));

    // R10: abort a load early, old mask must remain
    launch(1'b1, 0, 32'h1234_5678);
    d = $urandom;
    launch(1'b0, 2, d);
    await_done("R10");
    chk("R10 early abort", 64'(dout_o), 64'(model(1'b1, 1'b0, d, cur_mask)));

    // R10: abort a load exactly on its final step
    launch(1'b1, 0, 32'hDEAD_0F0F);
    repeat (S - 2) @(negedge clk);
    d = $urandom;
    launch(1'b0, 0, d);
    await_done("R10");
    chk("R10 final-step abort", 64'(dout_o), 64'(model(1'b0, 1'b0, d, cur_mask)));
    data_op(3, $urandom, "R10 R7 mask kept");

    $display("  test done: total=%0d bad=%0d", total, bad);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule